// File: doc/BRIEF.md
# Processor Status Word with Condition-Flag Logic

This block holds the 16-bit status word of a small 8/16-bit CPU datapath. After every executed instruction it takes the instruction's class, its operand width, the result value, and the ALU's carry/borrow and overflow indications. From these it updates the condition flags. One flag bit has two meanings. It records two's-complement overflow for arithmetic instructions and even parity for logic instructions. For bit-manipulation instructions the carry flag acts as a one-bit accumulator.

Software reads and writes the word one byte at a time, with one strobe for the high half and one for the low half. When the CPU returns from an interrupt or break, the whole word can be reloaded in a single cycle. The register-bank field, the auxiliary carry, the interrupt enable, the priority-transition bit and the user flag are stored and passed through. The flag logic does not interpret them.

Top module: `status_word`

## Requirements
- R1: For an arithmetic operation (`op_class`=1), CY (bit 0) takes `alu_carry`, which marks a carry out of or a borrow into bit 7 for byte operations or bit 15 for word operations.
- R2: For arithmetic and logic operations, Z (bit 6) is 1 exactly when the result is zero. A byte operation (`op_word`=0) tests `result[7:0]` and a word operation (`op_word`=1) tests all 16 bits.
- R3: For arithmetic and logic operations, S (bit 7) copies the result's MSB: `result[7]` for a byte operation and `result[15]` for a word operation.
- R4: For an arithmetic operation, P/V (bit 2) takes `alu_ovf`, which is the two's-complement overflow/underflow indication.
- R5: For a logic operation (`op_class`=2), P/V (bit 2) is 1 when the examined result bits contain an even number of ones and 0 when the count is odd. The examined bits are the same as in R2.
- R6: For a bit-manipulation operation (`op_class`=3), CY takes `bit_val` and every other bit is unchanged.
- R7: A logic operation leaves CY unchanged. Bits 5, 4, 3 and 1 and the whole high byte are never changed by flag updates. When `op_valid` is 0 or `op_class`=0, the word holds its value.
- R8: `wr_hi` loads `wr_data` into bits 15:8 and `wr_lo` loads it into bits 7:0. A low-byte write takes priority over a flag update in the same cycle. A high-byte write does not block that update.
- R9: `restore` loads `restore_data` into the whole word in one cycle and overrides byte writes and flag updates.
- R10: Reset clears all 16 bits to 0.
- R11: Bits 11:8 are reserved and always read 0, whatever is written or restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An instruction completes this cycle |
| op_class | input | 2 | 0 none, 1 arithmetic, 2 logic, 3 bit manipulation |
| op_word | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| result | input | 16 | Instruction result value |
| alu_carry | input | 1 | Carry out / borrow in at the operand MSB |
| alu_ovf | input | 1 | Two's-complement overflow indication |
| bit_val | input | 1 | Single-bit result of a bit-manipulation instruction |
| wr_hi | input | 1 | Software write strobe, high byte |
| wr_lo | input | 1 | Software write strobe, low byte |
| wr_data | input | 8 | Software write data |
| restore | input | 1 | Whole-word reload on return from interrupt |
| restore_data | input | 16 | Word to reload |
| psw_q | output | 16 | Current status word |

## Verification
The word is its own output register, so any wrong flag shows at `psw_q` in the cycle right after the instruction that set it. A flag that wrongly holds or wrongly changes would stay visible until the next update, write or restore of its byte. The bench keeps a reference word and compares every field after every cycle. Because the flags are compared field by field, a width mix-up (a byte test done on 16 bits), a swapped parity sense, or a write that loses its priority each shows up as a named field mismatch within one cycle.

// File: rtl/psw_pkg.sv
package psw_pkg;
   typedef enum logic [1:0] {
      OPC_NONE  = 2'd0,
      OPC_ARITH = 2'd1,
      OPC_LOGIC = 2'd2,
      OPC_BIT   = 2'd3
   } op_class_e;

   // low byte flag positions
   localparam int unsigned FB_CY = 0;
   localparam int unsigned FB_PV = 2;
   localparam int unsigned FB_Z  = 6;
   localparam int unsigned FB_S  = 7;
endpackage

// File: rtl/psw_parity.sv
module psw_parity #(
   parameter int unsigned W        = 16,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic [W-1:0] vec,
   output logic         even
);
   generate
      if (USE_TREE) begin : g_tree
         localparam int unsigned HALF = W / 2;
         logic [HALF-1:0] pair;
         logic            odd;
         always_comb begin
            for (int i = 0; i < HALF; i++) pair[i] = vec[2*i] ^ vec[2*i+1];
            odd = ^pair;
            if (W % 2 == 1) odd = odd ^ vec[W-1];
         end
         assign even = ~odd;
      end else begin : g_flat
         assign even = ~(^vec);
      end
   endgenerate
endmodule

// File: rtl/psw_flag_eval.sv
module psw_flag_eval
   import psw_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              op_valid,
   input  logic [1:0]        op_class,
   input  logic              op_word,
   input  logic [DATA_W-1:0] result,
   input  logic              alu_carry,
   input  logic              alu_ovf,
   input  logic              bit_val,
   input  logic [BYTE_W-1:0] cur_low,
   output logic              upd,
   output logic [BYTE_W-1:0] nxt_low
);
   logic [DATA_W-1:0] examined;
   logic              even_par;
   logic              msb;
   op_class_e         cls;

   assign cls      = op_class_e'(op_class);
   assign examined = op_word ? result : {{(DATA_W-BYTE_W){1'b0}}, result[BYTE_W-1:0]};
   assign msb      = op_word ? result[DATA_W-1] : result[BYTE_W-1];

   psw_parity #(.W(DATA_W), .USE_TREE(1'b1)) u_par (
      .vec  (examined),
      .even (even_par)
   );

   always_comb begin
      nxt_low = cur_low;
      upd     = op_valid && (cls != OPC_NONE);
      unique case (cls)
         OPC_ARITH: begin
            nxt_low[FB_CY] = alu_carry;
            nxt_low[FB_Z]  = (examined == '0);
            nxt_low[FB_S]  = msb;
            nxt_low[FB_PV] = alu_ovf;
         end
         OPC_LOGIC: begin
            nxt_low[FB_Z]  = (examined == '0);
            nxt_low[FB_S]  = msb;
            nxt_low[FB_PV] = even_par;
         end
         OPC_BIT:   nxt_low[FB_CY] = bit_val;
         default:   ;
      endcase
   end
endmodule

// File: rtl/status_word.sv
module status_word
   import psw_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned RSV_LO = 8,
   parameter int unsigned RSV_HI = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op_class,
   input  logic              op_word,
   input  logic [15:0]       result,
   input  logic              alu_carry,
   input  logic              alu_ovf,
   input  logic              bit_val,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [7:0]        wr_data,
   input  logic              restore,
   input  logic [15:0]       restore_data,
   output logic [15:0]       psw_q
);
   localparam int unsigned LANES = DATA_W / BYTE_W;
   localparam logic [DATA_W-1:0] KEEP_MASK =
      ~((({DATA_W{1'b1}}) << RSV_LO) & ~(({DATA_W{1'b1}}) << (RSV_HI + 1)));

   generate
      if (DATA_W != 2 * BYTE_W || DATA_W != 16) begin : g_bad_width
         $error("status_word: DATA_W must be 16 and twice BYTE_W");
      end
      if (RSV_HI < RSV_LO || RSV_HI >= DATA_W) begin : g_bad_rsv
         $error("status_word: reserved field out of range");
      end
   endgenerate

   logic [DATA_W-1:0] q;
   logic              flag_upd;
   logic [BYTE_W-1:0] flag_nxt;
   logic [LANES-1:0]  lane_wr;
   logic [LANES-1:0]  lane_upd;
   logic [BYTE_W-1:0] lane_nxt [LANES];

   psw_flag_eval #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_eval (
      .op_valid  (op_valid),
      .op_class  (op_class),
      .op_word   (op_word),
      .result    (result),
      .alu_carry (alu_carry),
      .alu_ovf   (alu_ovf),
      .bit_val   (bit_val),
      .cur_low   (q[BYTE_W-1:0]),
      .upd       (flag_upd),
      .nxt_low   (flag_nxt)
   );

   assign lane_wr = {wr_hi, wr_lo};

   genvar l;
   generate
      for (l = 0; l < LANES; l++) begin : g_lane
         if (l == 0) begin : g_flags
            assign lane_upd[l] = flag_upd;
            assign lane_nxt[l] = flag_nxt;
         end else begin : g_plain
            assign lane_upd[l] = 1'b0;
            assign lane_nxt[l] = q[l*BYTE_W +: BYTE_W];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[l*BYTE_W +: BYTE_W] <= '0;
            else if (restore)
               q[l*BYTE_W +: BYTE_W] <= restore_data[l*BYTE_W +: BYTE_W]
                                        & KEEP_MASK[l*BYTE_W +: BYTE_W];
            else if (lane_wr[l])
               q[l*BYTE_W +: BYTE_W] <= wr_data & KEEP_MASK[l*BYTE_W +: BYTE_W];
            else if (lane_upd[l])
               q[l*BYTE_W +: BYTE_W] <= lane_nxt[l];
         end
      end
   endgenerate

   assign psw_q = q;

   // ---------------- assertions ----------------
   p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      restore |=> psw_q == ($past(restore_data) & KEEP_MASK));

   p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      psw_q[RSV_HI:RSV_LO] == '0);

   p_bit_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_class == 2'd3 && !restore && !wr_lo)
      |=> psw_q[FB_CY] == $past(bit_val));

   p_arith_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_class == 2'd1 && !restore && !wr_lo)
      |=> psw_q[FB_CY] == $past(alu_carry));

   p_low_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !restore) |=> psw_q[7:0] == $past(wr_data));

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!restore && !wr_lo && !wr_hi && (!op_valid || op_class == 2'd0))
      |=> $stable(psw_q));
endmodule

// File: tb/sim_status_word.sv
module sim_status_word;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_class = 2'd0;
   logic        op_word = 1'b0;
   logic [15:0] result = '0;
   logic        alu_carry = 1'b0;
   logic        alu_ovf = 1'b0;
   logic        bit_val = 1'b0;
   logic        wr_hi = 1'b0;
   logic        wr_lo = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        restore = 1'b0;
   logic [15:0] restore_data = '0;
   logic [15:0] psw_q;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [15:0] model = '0;

   always #(PERIOD/2) clk = ~clk;

   status_word u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
      .op_word(op_word), .result(result), .alu_carry(alu_carry),
      .alu_ovf(alu_ovf), .bit_val(bit_val), .wr_hi(wr_hi), .wr_lo(wr_lo),
      .wr_data(wr_data), .restore(restore), .restore_data(restore_data),
      .psw_q(psw_q)
   );

   function automatic logic [15:0] next_word(logic [15:0] cur);
      logic [15:0] n = cur;
      logic [15:0] ex;
      ex = op_word ? result : {8'h00, result[7:0]};
      if (restore) return restore_data & 16'hF0FF;
      if (wr_hi) n[15:8] = wr_data & 8'hF0;
      if (wr_lo) n[7:0] = wr_data;
      else if (op_valid) begin
         case (op_class)
            2'd1: begin
               n[0] = alu_carry; n[6] = (ex == 0);
               n[7] = op_word ? result[15] : result[7]; n[2] = alu_ovf;
            end
            2'd2: begin
               n[6] = (ex == 0); n[7] = op_word ? result[15] : result[7];
               n[2] = ($countones(ex) % 2 == 0);
            end
            2'd3: n[0] = bit_val;
            default: ;
         endcase
      end
      return n;
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare_fields();
      string pv_tag = (op_valid && op_class == 2'd2) ? "R5 P/V" : "R4 P/V";
      string cy_tag = (op_valid && op_class == 2'd3) ? "R6 CY" :
                      (op_valid && op_class == 2'd2) ? "R7 CY" : "R1 CY";
      check("R3 S", {15'd0, psw_q[7]}, {15'd0, model[7]});
      check("R2 Z", {15'd0, psw_q[6]}, {15'd0, model[6]});
      check(pv_tag, {15'd0, psw_q[2]}, {15'd0, model[2]});
      check(cy_tag, {15'd0, psw_q[0]}, {15'd0, model[0]});
      check("R7/R8/R9 other bits", psw_q & 16'hFF3A, model & 16'hFF3A);
      check("R11 reserved", {12'd0, psw_q[11:8]}, 16'd0);
   endtask

   // one cycle: inputs already set at negedge; advance and compare
   task automatic step();
      model = next_word(model);
      @(posedge clk);
      @(negedge clk);
      compare_fields();
   endtask

   task automatic idle_inputs();
      op_valid = 0; op_class = 0; wr_hi = 0; wr_lo = 0; restore = 0;
   endtask

   task automatic do_op(logic [1:0] c, logic w, logic [15:0] r,
                        logic cy, logic ov, logic bv);
      idle_inputs();
      op_valid = 1; op_class = c; op_word = w; result = r;
      alu_carry = cy; alu_ovf = ov; bit_val = bv;
      step();
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check("R10 reset", psw_q, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after release", psw_q, 16'h0000);

      // directed corners
      do_op(2'd2, 1'b0, 16'h0100, 0, 0, 0);   // byte zero, even parity
      check("R2 byte Z on 0x0100", {15'd0, psw_q[6]}, 16'd1);
      check("R5 parity of zero", {15'd0, psw_q[2]}, 16'd1);
      do_op(2'd2, 1'b1, 16'h0100, 0, 0, 0);   // word nonzero, odd
      check("R2 word Z on 0x0100", {15'd0, psw_q[6]}, 16'd0);
      check("R5 odd parity", {15'd0, psw_q[2]}, 16'd0);
      do_op(2'd1, 1'b0, 16'h8000, 1, 1, 0);
      check("R3 byte S uses bit7", {15'd0, psw_q[7]}, 16'd0);
      check("R1 carry set", {15'd0, psw_q[0]}, 16'd1);
      check("R4 overflow set", {15'd0, psw_q[2]}, 16'd1);
      do_op(2'd2, 1'b1, 16'h8001, 0, 0, 0);
      check("R7 logic keeps CY", {15'd0, psw_q[0]}, 16'd1);
      do_op(2'd3, 1'b0, 16'h0000, 1, 1, 0);
      check("R6 bit acc clear CY", {15'd0, psw_q[0]}, 16'd0);

      // low write beats flag update; high write coexists
      idle_inputs();
      op_valid = 1; op_class = 2'd1; result = 16'h0000; alu_carry = 1;
      wr_lo = 1; wr_hi = 1; wr_data = 8'hAF;
      step();
      check("R8 low write priority", {8'd0, psw_q[7:0]}, 16'h00AF);
      check("R11 high write masked", {8'd0, psw_q[15:8]}, 16'h00A0);
      idle_inputs();
      wr_hi = 1; wr_data = 8'h50; op_valid = 1; op_class = 2'd3; bit_val = 0;
      step();
      check("R8 hi write with update", psw_q, 16'h50AE);
      idle_inputs();
      restore = 1; restore_data = 16'hFFFF; wr_lo = 1; wr_data = 8'h00;
      op_valid = 1; op_class = 2'd1;
      step();
      check("R9 restore overrides", psw_q, 16'hF0FF);
      idle_inputs();
      op_valid = 1; op_class = 2'd0; result = 16'h1234;
      step();
      check("R7 class none holds", psw_q, 16'hF0FF);

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         idle_inputs();
         op_valid     = ($urandom % 8) != 0;
         op_class     = 2'($urandom % 4);
         op_word      = 1'($urandom);
         result       = (($urandom % 6) == 0) ? 16'h0000 :
                        (($urandom % 5) == 0) ? 16'h0100 : 16'($urandom);
         alu_carry    = 1'($urandom);
         alu_ovf      = 1'($urandom);
         bit_val      = 1'($urandom);
         wr_hi        = ($urandom % 8) == 0;
         wr_lo        = ($urandom % 8) == 0;
         wr_data      = 8'($urandom);
         restore      = ($urandom % 16) == 0;
         restore_data = 16'($urandom);
         step();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule